// File: doc/BRIEF.md
# Keyed-Sequence Nonvolatile Shadow Memory

This block is a synchronous byte memory paired with a nonvolatile shadow array of the same depth. It behaves as an ordinary static memory. Active-low chip-enable, output-enable and write-enable strobes are sampled on each rising clock edge. Read data comes back one clock later, together with a valid flag. A write puts the input byte into the addressed location. The valid flag stands in for a tristate data bus: when it is low, the output is treated as high impedance.

Two special operations are reached only through a keyed series of six reads. No command pins are used. Five fixed key addresses must be read in order, with no other access between them. The sixth read then selects the operation:
- one address saves the whole working array into the shadow (STORE), as an erase pass followed by a program pass;
- a neighbouring address copies the shadow back into the working array (RECALL).

While either copy runs, `busy` is high, every access is ignored and no read data is produced.

The address width is a parameter. Its default of 11 bits gives a 2048-byte array; setting it to 13 gives the full 8192-byte part. Each key address is the low `ADDR_W` bits of a 13-bit key value. The 13-bit keys are 0x0000, 0x1555, 0x0AAA, 0x1FFF and 0x10F0, then 0x0F0F for STORE or 0x0F0E for RECALL. At the default width these become 0x000, 0x555, 0x2AA, 0x7FF and 0x0F0, then 0x70F or 0x70E. The phase lengths must each be at least the array depth.

Top module: `nvkey_sram`

## Requirements
- R1: A read access happens on a clock edge where `ce_n`=0, `oe_n`=0 and `we_n`=1. After that edge, `dout` holds the addressed byte and `dout_vld` is 1.
- R2: A write access happens on a clock edge where `ce_n`=0 and `we_n`=0. The `din` byte is stored at `addr`, and `dout_vld` is 0 after that edge.
- R3: On an edge with `ce_n`=1, or with `oe_n`=1, or with `we_n`=0, no read data is produced and `dout_vld` is 0 after that edge.
- R4: A STORE starts on the sixth access of this series of accesses with `ce_n`=0 and `we_n`=1: addresses key0..key4 in order, then the store key. `oe_n` may be 1 on any of them. `busy` rises after the sixth edge.
- R5: A STORE keeps `busy` high for exactly ERASE_CYC+PROG_CYC clocks. Afterwards, the shadow holds the working array as it stood when the STORE began.
- R6: A RECALL starts when the sixth access of the same series hits the recall key. It keeps `busy` high for exactly RECALL_CYC clocks. Afterwards, every working byte equals the shadow.
- R7: Lockout covers the sixth access edge and every edge while `busy` is high. During lockout, `dout_vld` stays 0, writes change nothing and no access advances the key series.
- R8: A write anywhere, or a read that does not match the next expected key, abandons the partial series. A later store or recall key then starts nothing.
- R9: A read of key0 that breaks a partial series counts as the first step of a new series.
- R10: After reset, `busy` and `dout_vld` are 0 and the key series is at its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, meaningful only when dout_vld is 1 |
| dout_vld | output | 1 | Read data valid (0 stands for high impedance) |
| busy | output | 1 | STORE or RECALL in progress |

## Verification
The assertions assume that the strobes are ordinary clean levels sampled once per edge. They also assume that the phase-length parameters match the values bound into the checker, so that a busy window has exactly one of two legal lengths. The stimulus drives every strobe and address at the falling edge, so each rising edge sees a single settled access. Random accesses are biased toward the key addresses, so that partial, broken and restarted key series occur among ordinary traffic. Full STORE and RECALL series are issued directly, each time with accesses attempted during the lockout.

// File: rtl/nvkey_sram.sv
module nvkey_sram #(
  parameter int ADDR_W     = 11,
  parameter int ERASE_CYC  = 2048,
  parameter int PROG_CYC   = 2048,
  parameter int RECALL_CYC = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_vld,
  output logic              busy
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int MAXC  = (ERASE_CYC > PROG_CYC) ?
                         ((ERASE_CYC > RECALL_CYC) ? ERASE_CYC : RECALL_CYC) :
                         ((PROG_CYC > RECALL_CYC) ? PROG_CYC : RECALL_CYC);
  localparam int CW    = ($clog2(MAXC + 1) > ADDR_W + 1) ? $clog2(MAXC + 1) : ADDR_W + 1;
  localparam logic [31:0] STORE_K  = 32'h0F0F;
  localparam logic [31:0] RECALL_K = 32'h0F0E;
  localparam logic [ADDR_W-1:0] K_ST = STORE_K[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] K_RC = RECALL_K[ADDR_W-1:0];

  typedef enum logic [1:0] {PH_IDLE, PH_ERASE, PH_PROG, PH_RECALL} phase_t;

  function automatic logic [ADDR_W-1:0] key_at(input logic [2:0] s);
    logic [31:0] k;
    case (s)
      3'd1:    k = 32'h1555;
      3'd2:    k = 32'h0AAA;
      3'd3:    k = 32'h1FFF;
      3'd4:    k = 32'h10F0;
      default: k = 32'h0000;
    endcase
    return k[ADDR_W-1:0];
  endfunction

  logic [7:0]  sram   [DEPTH];
  logic [7:0]  shadow [DEPTH];
  phase_t      phase;
  logic [CW-1:0] cnt;
  logic [2:0]  step, step_nx;

  wire idle   = (phase == PH_IDLE);
  wire rd_acc = idle && !ce_n && we_n;
  wire wr_acc = idle && !ce_n && !we_n;
  wire rd_out = rd_acc && !oe_n;
  wire last   = (step == 3'd5);
  wire go_st  = rd_acc && last && (addr == K_ST);
  wire go_rc  = rd_acc && last && (addr == K_RC);
  wire in_rng = (32'(cnt) < DEPTH);
  wire [ADDR_W-1:0] cidx = cnt[ADDR_W-1:0];

  assign busy = !idle;

  always_comb begin
    step_nx = step;
    if (wr_acc)
      step_nx = 3'd0;
    else if (rd_acc) begin
      if (!last && addr == key_at(step)) step_nx = step + 3'd1;
      else if (addr == key_at(3'd0))     step_nx = 3'd1;
      else                               step_nx = 3'd0;
      if (go_st || go_rc) step_nx = 3'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      step     <= 3'd0;
      dout_vld <= 1'b0;
    end else begin
      step     <= step_nx;
      dout_vld <= rd_out && !go_st && !go_rc;
      case (phase)
        PH_IDLE: begin
          cnt <= '0;
          if (go_st)      phase <= PH_ERASE;
          else if (go_rc) phase <= PH_RECALL;
        end
        PH_ERASE:
          if (cnt == CW'(ERASE_CYC - 1)) begin
            phase <= PH_PROG;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        PH_PROG:
          if (cnt == CW'(PROG_CYC - 1)) begin
            phase <= PH_IDLE;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        default:
          if (cnt == CW'(RECALL_CYC - 1)) begin
            phase <= PH_IDLE;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr_acc)
      sram[addr] <= din;
    else if (phase == PH_RECALL && in_rng)
      sram[cidx] <= shadow[cidx];
    if (rd_out)
      dout <= sram[addr];
    if (phase == PH_ERASE && in_rng)
      shadow[cidx] <= 8'hFF;
    else if (phase == PH_PROG && in_rng)
      shadow[cidx] <= sram[cidx];
  end
endmodule

// File: rtl/nvkey_sram_chk.sv
module nvkey_sram_chk #(
  parameter int ERASE_CYC  = 2048,
  parameter int PROG_CYC   = 2048,
  parameter int RECALL_CYC = 2048
) (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic oe_n,
  input logic we_n,
  input logic dout_vld,
  input logic busy
);
  int unsigned blen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    blen <= 0;
    else if (busy) blen <= blen + 1;
    else           blen <= 0;
  end

  AST_VALID_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    dout_vld |-> $past(!ce_n && !oe_n && we_n)); // R1

  AST_NO_VALID_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !we_n) |=> !dout_vld); // R2

  AST_NO_VALID_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n || ce_n) |=> !dout_vld); // R3

  AST_BUSY_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!ce_n && we_n)); // R4

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (blen == ERASE_CYC + PROG_CYC || blen == RECALL_CYC)); // R5

  AST_LOCKOUT_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !dout_vld); // R7

  AST_LOCKOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !dout_vld); // R7
endmodule

bind nvkey_sram nvkey_sram_chk #(
  .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC), .RECALL_CYC(RECALL_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .dout_vld(dout_vld), .busy(busy)
);

// File: tb/nvkey_sram_bench.sv
module nvkey_sram_bench;
  localparam int AW = 11;
  localparam int DEPTH = 1 << AW;
  localparam int EC = 2048, PC = 2048, RC = 2048;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic dout_vld, busy;

  always #4 clk = ~clk;

  nvkey_sram u_nvkey_sram (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_vld(dout_vld), .busy(busy)
  );

  logic [7:0] m_sram [DEPTH];
  logic [7:0] m_shad [DEPTH];
  int m_step = 0, m_left = 0;
  bit m_vld = 0;
  logic [7:0] m_dout = '0;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  function automatic logic [AW-1:0] bk(input int i);
    logic [31:0] k;
    case (i)
      1: k = 32'h1555; 2: k = 32'h0AAA; 3: k = 32'h1FFF; 4: k = 32'h10F0;
      5: k = 32'h0F0F; 6: k = 32'h0F0E; default: k = 32'h0000;
    endcase
    return k[AW-1:0];
  endfunction

  function automatic int next_step(input int s, input logic [AW-1:0] a);
    if (s < 5 && a == bk(s)) return s + 1;
    if (a == bk(0)) return 1;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic cyc(input bit ce, input bit oe, input bit we,
                     input logic [AW-1:0] a, input logic [7:0] d, input string req);
    bit rda, wra, rdo, ts, tr;
    ce_n = ce; oe_n = oe; we_n = we; addr = a; din = d;
    if (m_left > 0) begin
      m_left--;
      m_vld = 0;
    end else begin
      rda = !ce && we; wra = !ce && !we; rdo = rda && !oe;
      ts = rda && m_step == 5 && a == bk(5);
      tr = rda && m_step == 5 && a == bk(6);
      m_vld = rdo && !ts && !tr;
      if (rdo) m_dout = m_sram[a];
      if (wra) begin m_sram[a] = d; m_step = 0; end
      else if (rda) m_step = (ts || tr) ? 0 : next_step(m_step, a);
      if (ts) begin
        for (int i = 0; i < DEPTH; i++) m_shad[i] = m_sram[i];
        m_left = EC + PC;
      end
      if (tr) begin
        for (int i = 0; i < DEPTH; i++) m_sram[i] = m_shad[i];
        m_left = RC;
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk(busy == (m_left > 0), req, "busy", int'(busy), int'(m_left > 0));
    chk(dout_vld == m_vld, req, "dout_vld", int'(dout_vld), int'(m_vld));
    if (m_vld) chk(dout == m_dout, req, "dout", int'(dout), int'(m_dout));
  endtask

  task automatic idle(input string req);
    cyc(1, 1, 1, '0, '0, req);
  endtask

  task automatic rd(input logic [AW-1:0] a, input bit oe, input string req);
    cyc(0, oe, 1, a, '0, req);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input string req);
    cyc(0, 1, 0, a, d, req);
  endtask

  task automatic prefix(input bit oe, input string req);
    for (int i = 0; i < 5; i++) rd(bk(i), oe, req);
  endtask

  task automatic wait_busy(input string req);
    int guard = 0;
    while (m_left > 0 && guard < 10000) begin
      if (guard == 10) wr(bk(3), 8'h5A, "R7");
      else if (guard == 11) rd(bk(3), 0, "R7");
      else if (guard == 12) rd(bk(0), 1, "R7");
      else idle(req);
      guard++;
    end
  endtask

  initial begin
    #(8 * 190000);
    chk(0, "WDOG", "timeout", 0, 1);
    summary();
  end

  initial begin
    void'($urandom(32'd13));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(busy == 0, "R10", "reset busy", int'(busy), 0);
    chk(dout_vld == 0, "R10", "reset dout_vld", int'(dout_vld), 0);

    for (int i = 0; i < DEPTH; i++) wr(AW'(i), 8'($urandom), "R2");
    rd(AW'(5), 0, "R1");
    rd(AW'(DEPTH - 1), 0, "R1");
    rd(AW'(7), 1, "R3");
    cyc(1, 0, 1, AW'(7), '0, "R3");
    wr(AW'(9), 8'hC3, "R2");
    rd(AW'(9), 0, "R2");

    prefix(1, "R4");
    rd(bk(5), 1, "R4");
    chk(busy == 1, "R4", "store started", int'(busy), 1);
    wait_busy("R5");
    rd(bk(3), 0, "R7");

    for (int i = 0; i < 16; i++) wr(AW'(i * 37), 8'(i + 1), "R2");
    prefix(0, "R6");
    rd(bk(6), 0, "R6");
    wait_busy("R6");
    for (int i = 0; i < 16; i++) rd(AW'(i * 37), 0, "R6");

    prefix(0, "R8");
    wr(AW'(100), 8'h11, "R8");
    rd(bk(5), 0, "R8");
    chk(busy == 0, "R8", "abort by write", int'(busy), 0);
    rd(bk(0), 0, "R8"); rd(bk(1), 0, "R8"); rd(AW'(3), 0, "R8");
    rd(bk(2), 0, "R8"); rd(bk(3), 0, "R8"); rd(bk(4), 0, "R8");
    rd(bk(6), 0, "R8");
    chk(busy == 0, "R8", "abort by stray read", int'(busy), 0);
    prefix(0, "R8");
    rd(AW'(1), 0, "R8");
    chk(busy == 0, "R8", "wrong sixth read", int'(busy), 0);

    rd(bk(0), 0, "R9"); rd(bk(1), 0, "R9"); rd(bk(2), 0, "R9");
    prefix(0, "R9");
    rd(bk(6), 0, "R9");
    chk(busy == 1, "R9", "restart at key0", int'(busy), 1);
    wait_busy("R9");

    for (int n = 0; n < 4000; n++) begin
      int r = int'($urandom % 10);
      logic [AW-1:0] a = ($urandom % 4 == 0) ? bk(int'($urandom % 7)) : AW'($urandom);
      if (m_left > 0) idle("R7");
      else if (r < 5) rd(a, ($urandom % 5) == 0, "R1");
      else if (r < 8) wr(a, 8'($urandom), "R2");
      else idle("R3");
    end
    summary();
  end
endmodule